// File: doc/BRIEF.md
# Vector Mask Compress Unit

This unit turns a vector register into a list of element positions. Pulse `start` while the unit is idle. The unit then captures the source vector, the test condition and the vector length. In the first phase it tests one element per cycle against the chosen condition and builds a mask register with one bit per element. In the second phase it walks the mask from the lowest position upward, again one element per cycle. It writes the position of every set bit into the next free slot of an index vector and counts the selected elements.

The index vector is dense. The first selected position goes to slot 0, the next to slot 1, and so on. The result feeds later indexed operations, which take the positions in ascending order. Slots at and above the final count are not written, so they keep whatever an earlier run left there. A one-cycle `done` pulse marks the point where the mask, the index vector and the count are all final.

Top module: `vmask_compress`

## Requirements
- R1: After reset, `busy` and `done` are low, and `mask_out`, `sel_count` and every slot of `idx_flat` are zero.
- R2: Elements are two's-complement numbers of `ELEM_W` bits. An element sets its mask bit when it meets the condition picked by `cond_sel`: 0 = equal to zero, 1 = not zero, 2 = strictly positive, 3 = negative.
- R3: Only elements 0 to VL-1 are tested. Mask bits at position VL and above are zero when `done` is high.
- R4: Slot j of `idx_flat` occupies bits [j*IDX_W +: IDX_W]. Slot j receives the position of the (j+1)-th set mask bit, counted from position 0 upward, so the filled slots are contiguous from slot 0 and strictly ascending.
- R5: When `done` is high, `sel_count` equals the number of set bits in `mask_out`.
- R6: Slots at and above `sel_count` keep the values they held before the run.
- R7: `start` is accepted only while `busy` is low. Call the clock edge that accepts it edge 0. `done` is high for exactly one cycle, after edge 2*VL. `busy` stays high from edge 0 until `done` falls.
- R8: A `vec_len` above `NUM_ELEM` is treated as `NUM_ELEM`. A `vec_len` of zero gives an all-zero mask and a count of zero, and `done` rises after edge 0.
- R9: A `start` pulse that arrives while `busy` is high is ignored, along with the `vec_len` and `cond_sel` values presented with it.
- R10: `src_flat` is sampled on the accepting edge only. Changing it during a run has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted while idle) |
| cond_sel | input | 2 | Test condition code (R2) |
| vec_len | input | LEN_W | Number of elements taking part |
| src_flat | input | NUM_ELEM*ELEM_W | Source vector, element k at [k*ELEM_W +: ELEM_W] |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| mask_out | output | NUM_ELEM | Test mask, bit k for element k |
| idx_flat | output | NUM_ELEM*IDX_W | Packed index vector |
| sel_count | output | LEN_W | Number of selected elements |

## Verification
The bench builds the unit with 16 elements of 12 bits, so `vec_len` is 5 bits wide. That width lets the bench request lengths above the element count and so reach the clamp. With these sizes a full-length run fills every index slot, and the run lengths stay short enough to check the cycle count of each one. The narrow elements also make the extreme values easy to apply: the most negative value, the largest positive value, and zero all appear in the condition tests.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  typedef enum logic [1:0] {
    COND_ZERO    = 2'd0,
    COND_NONZERO = 2'd1,
    COND_POS     = 2'd2,
    COND_NEG     = 2'd3
  } cond_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TEST = 2'd1,
    ST_PACK = 2'd2,
    ST_DONE = 2'd3
  } phase_t;
endpackage

// File: rtl/vmc_ctrl.sv
module vmc_ctrl
  import vmc_pkg::*;
#(
  parameter int NUM_ELEM = 64,
  parameter int IDX_W    = 6,
  parameter int LEN_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] vec_len,
  output logic             accept,
  output logic             test_en,
  output logic             pack_en,
  output logic [IDX_W-1:0] pos,
  output logic [LEN_W-1:0] len_q,
  output logic             busy,
  output logic             done
);
  phase_t phase_q;
  logic   last_elem;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] req);
    if (int'(req) > NUM_ELEM) return LEN_W'(NUM_ELEM);
    return req;
  endfunction

  assign accept    = start && (phase_q == ST_IDLE);
  assign test_en   = (phase_q == ST_TEST);
  assign pack_en   = (phase_q == ST_PACK);
  assign busy      = (phase_q != ST_IDLE);
  assign done      = (phase_q == ST_DONE);
  assign last_elem = ((LEN_W'(pos) + LEN_W'(1)) == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      pos     <= '0;
      len_q   <= '0;
    end else begin
      unique case (phase_q)
        ST_IDLE: if (accept) begin
          len_q   <= clamp_len(vec_len);
          pos     <= '0;
          phase_q <= (clamp_len(vec_len) == '0) ? ST_DONE : ST_TEST;
        end
        ST_TEST: begin
          pos     <= last_elem ? '0 : pos + IDX_W'(1);
          phase_q <= last_elem ? ST_PACK : ST_TEST;
        end
        ST_PACK: begin
          pos     <= last_elem ? '0 : pos + IDX_W'(1);
          phase_q <= last_elem ? ST_DONE : ST_PACK;
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(len_q));
  assert_len_clamped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(len_q) <= NUM_ELEM);
  assert_pos_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en || pack_en) |-> (LEN_W'(pos) < len_q));
endmodule

// File: rtl/vmc_mask_gen.sv
module vmc_mask_gen
  import vmc_pkg::*;
#(
  parameter int NUM_ELEM = 64,
  parameter int ELEM_W   = 64,
  parameter int IDX_W    = 6,
  parameter int LEN_W    = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [1:0]                 cond_in,
  input  logic [NUM_ELEM*ELEM_W-1:0] src_flat,
  input  logic                       test_en,
  input  logic [IDX_W-1:0]           pos,
  input  logic [LEN_W-1:0]           len_q,
  output logic [NUM_ELEM-1:0]        mask
);
  logic [ELEM_W-1:0] src_q [NUM_ELEM];
  cond_t             cond_q;
  logic              elem_hit;

  function automatic logic elem_pass(input logic [ELEM_W-1:0] v, input cond_t c);
    unique case (c)
      COND_ZERO:    return (v == '0);
      COND_NONZERO: return (v != '0);
      COND_POS:     return !v[ELEM_W-1] && (v != '0);
      default:      return v[ELEM_W-1];
    endcase
  endfunction

  function automatic logic [NUM_ELEM-1:0] below_len(input logic [LEN_W-1:0] n);
    logic [NUM_ELEM-1:0] m;
    for (int k = 0; k < NUM_ELEM; k++) m[k] = (k < int'(n));
    return m;
  endfunction

  assign elem_hit = elem_pass(src_q[pos], cond_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_ELEM; k++) src_q[k] <= '0;
      cond_q <= COND_ZERO;
      mask   <= '0;
    end else if (load) begin
      for (int k = 0; k < NUM_ELEM; k++) src_q[k] <= src_flat[k*ELEM_W +: ELEM_W];
      cond_q <= cond_t'(cond_in);
      mask   <= '0;
    end else if (test_en) begin
      mask[pos] <= elem_hit;
    end
  end

  assert_mask_tail_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~below_len(len_q)) == '0);
endmodule

// File: rtl/vmc_packer.sv
module vmc_packer #(
  parameter int NUM_ELEM = 64,
  parameter int IDX_W    = 6,
  parameter int LEN_W    = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      pack_en,
  input  logic [IDX_W-1:0]          pos,
  input  logic                      bit_in,
  output logic [NUM_ELEM*IDX_W-1:0] idx_flat,
  output logic [LEN_W-1:0]          count
);
  logic [IDX_W-1:0] slot_q [NUM_ELEM];
  logic             slot_wr;

  assign slot_wr = pack_en && bit_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_ELEM; k++) slot_q[k] <= '0;
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (slot_wr) begin
      slot_q[count[IDX_W-1:0]] <= pos;
      count <= count + LEN_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_flat
    assign idx_flat[g*IDX_W +: IDX_W] = slot_q[g];
  end

  assert_pack_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr |-> (LEN_W'(pos) >= count));
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= NUM_ELEM);
endmodule

// File: rtl/vmask_compress.sv
module vmask_compress #(
  parameter int NUM_ELEM = 64,
  parameter int ELEM_W   = 64,
  localparam int IDX_W   = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
  localparam int LEN_W   = $clog2(NUM_ELEM + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [1:0]                 cond_sel,
  input  logic [LEN_W-1:0]           vec_len,
  input  logic [NUM_ELEM*ELEM_W-1:0] src_flat,
  output logic                       busy,
  output logic                       done,
  output logic [NUM_ELEM-1:0]        mask_out,
  output logic [NUM_ELEM*IDX_W-1:0]  idx_flat,
  output logic [LEN_W-1:0]           sel_count
);
  logic             accept;
  logic             test_en;
  logic             pack_en;
  logic [IDX_W-1:0] pos;
  logic [LEN_W-1:0] len_q;

  vmc_ctrl #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
    .accept(accept), .test_en(test_en), .pack_en(pack_en), .pos(pos),
    .len_q(len_q), .busy(busy), .done(done)
  );

  vmc_mask_gen #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) mask_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .cond_in(cond_sel),
    .src_flat(src_flat), .test_en(test_en), .pos(pos), .len_q(len_q),
    .mask(mask_out)
  );

  vmc_packer #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .LEN_W(LEN_W)) pack_i (
    .clk(clk), .rst_n(rst_n), .clr(accept), .pack_en(pack_en), .pos(pos),
    .bit_in(mask_out[pos]), .idx_flat(idx_flat), .count(sel_count)
  );

  assert_count_popcount_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(sel_count) == $countones(mask_out)));
endmodule

// File: tb/vmask_compress_tb_top.sv
`timescale 1ns/1ps
module vmask_compress_tb_top;
  localparam int NE = 16;
  localparam int EW = 12;
  localparam int IW = 4;
  localparam int LW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, start;
  logic [1:0]       cond_sel;
  logic [LW-1:0]    vec_len;
  logic [NE*EW-1:0] src_flat;
  logic             busy, done;
  logic [NE-1:0]    mask_out;
  logic [NE*IW-1:0] idx_flat;
  logic [LW-1:0]    sel_count;

  logic [EW-1:0] src [NE];
  for (genvar g = 0; g < NE; g++) begin : g_src
    assign src_flat[g*EW +: EW] = src[g];
  end

  vmask_compress #(.NUM_ELEM(NE), .ELEM_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cond_sel(cond_sel),
    .vec_len(vec_len), .src_flat(src_flat), .busy(busy), .done(done),
    .mask_out(mask_out), .idx_flat(idx_flat), .sel_count(sel_count)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [IW-1:0] m_idx [NE];
  logic [NE-1:0] m_mask;
  int            m_cnt;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL R7 watchdog expired actual=%0d expected=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ref_pass(input logic [EW-1:0] v, input logic [1:0] c);
    logic signed [EW-1:0] s;
    s = v;
    case (c)
      2'd0: return s == 0;
      2'd1: return s != 0;
      2'd2: return s > 0;
      default: return s < 0;
    endcase
  endfunction

  task automatic model_run(input int vl, input logic [1:0] c);
    int eff;
    eff = (vl > NE) ? NE : vl;
    m_mask = '0;
    m_cnt = 0;
    for (int i = 0; i < eff; i++) begin
      if (ref_pass(src[i], c)) begin
        m_mask[i] = 1'b1;
        m_idx[m_cnt] = IW'(i);
        m_cnt++;
      end
    end
  endtask

  task automatic check_results(input string req);
    chk({req, " mask"}, 64'(mask_out), 64'(m_mask));
    chk({req, " count"}, 64'(sel_count), 64'(m_cnt));
    for (int j = 0; j < NE; j++)
      chk({req, " slot"}, 64'(idx_flat[j*IW +: IW]), 64'(m_idx[j]));
  endtask

  task automatic run_op(input int vl, input logic [1:0] c, input string req, input bit disturb);
    int k, eff;
    eff = (vl > NE) ? NE : vl;
    @(negedge clk);
    cond_sel = c; vec_len = LW'(vl); start = 1'b1;
    model_run(vl, c);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    if (eff > 0) chk("R7 busy after start", 64'(busy), 64'd1);
    while (!done && k < 400) begin
      if (disturb && k == 2) begin
        start = 1'b1; vec_len = LW'(3); cond_sel = ~c;
        for (int i = 0; i < NE; i++) src[i] = ~src[i];
      end else if (disturb && k == 3) begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    chk({req, " R7 latency"}, 64'(k), 64'(2*eff));
    check_results(req);
    @(negedge clk);
    chk("R7 done one cycle", 64'(done), 64'd0);
    chk("R7 busy cleared", 64'(busy), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 mask", 64'(mask_out), 64'd0);
    chk("R1 count", 64'(sel_count), 64'd0);
    chk("R1 slots", 64'(idx_flat), 64'd0);
    for (int j = 0; j < NE; j++) m_idx[j] = '0;
  endtask

  task automatic t_doc_pattern;
    logic [IW-1:0] want [6];
    want = '{4'd1, 4'd3, 4'd4, 4'd7, 4'd8, 4'd9};
    for (int i = 0; i < NE; i++) src[i] = '0;
    src[1] = 12'd5; src[3] = 12'hFFD; src[4] = 12'd7;
    src[7] = 12'd1; src[8] = 12'd2; src[9] = 12'd9; src[12] = 12'd4;
    run_op(10, 2'd1, "R2/R4 pattern", 1'b0);
    for (int j = 0; j < 6; j++) chk("R4 literal slot", 64'(idx_flat[j*IW +: IW]), 64'(want[j]));
    chk("R5 literal count", 64'(sel_count), 64'd6);
  endtask

  task automatic t_conditions;
    for (int i = 0; i < NE; i++) src[i] = EW'(i * 173 - 1100);
    src[2] = '0; src[5] = 12'h800; src[6] = 12'h7FF; src[11] = '0; src[14] = 12'hFFF;
    for (int c = 0; c < 4; c++) run_op(16, 2'(c), "R2 condition", 1'b0);
  endtask

  task automatic t_short;
    for (int i = 0; i < NE; i++) src[i] = 12'd1;
    src[3] = '0;
    run_op(6, 2'd3, "R6 keep slots", 1'b0);
    for (int i = 0; i < NE; i++) src[i] = 12'd1;
    run_op(5, 2'd1, "R3/R6 short", 1'b0);
    chk("R3 tail mask", 64'(mask_out), 64'h1F);
  endtask

  task automatic t_lengths;
    for (int i = 0; i < NE; i++) src[i] = (i % 3 == 0) ? 12'd0 : 12'd9;
    run_op(20, 2'd0, "R8 clamp", 1'b0);
    run_op(0, 2'd0, "R8 zero length", 1'b0);
    chk("R8 zero mask", 64'(mask_out), 64'd0);
  endtask

  task automatic t_busy_start;
    for (int i = 0; i < NE; i++) src[i] = (i % 2 == 1) ? 12'hF00 : 12'd3;
    run_op(12, 2'd3, "R9/R10 disturb", 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cond_sel = '0; vec_len = '0;
    for (int i = 0; i < NE; i++) src[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_doc_pattern();
    t_conditions();
    t_short();
    t_lengths();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule